// File: doc/BRIEF.md
# GPIO Event Port

An eight-pin general-purpose I/O port controlled through a small memory-mapped register bus. Software programs each pin through its own 32-byte window: whether the pin is in use, whether it drives, what it should watch for and whether that should raise an interrupt. Pads are driven through separate output-value and output-enable signals, so a float control can release a pin that is set as an output.

Every pad input is synchronised through two flops and can optionally be filtered by a per-pin stability counter. The filtered value feeds an event detector that supports level, single-edge and double-edge triggering. Detected events latch into sticky per-pin status bits. Software reads these bits as one status word and clears them pin by pin. A single interrupt line combines all pins that have status pending and interrupts allowed.

Top module: `gpio_event_port`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is all zero and `irq` is 0.
- R2: Pin n's window starts at byte address n*0x20. Offset 0x00 holds an 8-bit config (bit0 enable, bit1 output direction, bits3:2 trigger mode, bit4 polarity, bit5 debounce enable, bit6 interrupt enable, bit7 timestamp enable). Offset 0x04 holds a 16-bit debounce threshold. Bit0 of offset 0x0C is float and bit0 of offset 0x10 is the output value. A register reads back what was written. Read data for an address appears on the clock edge after that address is presented.
- R3: `pad_oe[n]` is 1 exactly when pin n is enabled, set as an output and not floated. `pad_out[n]` follows that pin's output value bit.
- R4: Bit0 of offset 0x08 reads the pin's input after a two-flop synchroniser.
- R5: Trigger mode 0 detects nothing. Mode 2 detects a rising edge when polarity is 1 and a falling edge when polarity is 0. Mode 3 detects both edges whatever the polarity. No events are detected while the pin's enable bit is 0.
- R6: A detected event sets that pin's status bit, which then holds. Writing a word with bit0 = 1 to offset 0x14 clears it. Writing bit0 = 0 leaves it set. An event in the same cycle as the clear keeps the bit set.
- R7: In mode 1 the status bit is set on every cycle in which the input equals the polarity bit, so a clear has no lasting effect while the level is active.
- R8: With debounce enabled and a nonzero threshold T, a new input level is accepted only after the synchronised input has held it for T cycles, so shorter pulses produce no event. A threshold of 0 gives no filtering.
- R9: Address 0x100 reads the status bits of pins 0..7 in bits 7:0. Every other address with bit 8 set, the clear register and unused offsets in a pin window all read zero.
- R10: `irq` is 1 when any pin has its status set with both enable and interrupt enable at 1. A status bit with interrupts disabled stays readable but does not drive `irq`. The timestamp enable bit only reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after address |
| pad_in | input | 8 | Asynchronous pad inputs |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad driver enables |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that a clear is only requested through a full write with bit0 set at a pin's offset 0x14, and that a write to the 0x100 page has no effect, so unmapped reads stay zero. They also assume the pad inputs may change at any time, because they check only synchronised and filtered state. The bench changes pads on the falling clock edge and holds each level for a fixed number of cycles, well clear of the synchroniser and filter latencies. Random register traffic is kept to the four writable per-pin offsets, with the pads held low.

// File: rtl/gpio_event_port.sv
module gpio_event_port #(
  parameter int PINS = 8,
  parameter int DBW  = 16,
  parameter int DW   = 32,
  parameter int AW   = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe,
  output logic            irq
);
  localparam int WSH = 5;
  localparam int PB  = AW - 1 - WSH;
  localparam logic [WSH-1:0] O_CFG = 5'h00, O_TH = 5'h04, O_IN = 5'h08,
                             O_FLT = 5'h0C, O_OUT = 5'h10;
  localparam logic [WSH-1:0] O_CLR = 5'h14;

  logic [7:0]      cfg [PINS];
  logic [DBW-1:0]  th  [PINS];
  logic [DBW-1:0]  cnt [PINS];
  logic [PINS-1:0] flt, oval, s1, s2, filt, filt_d, stat, ev, clr;
  logic [PINS-1:0] en_v, dir_v, ien_v, armed_v;
  logic [DW-1:0]   rd_n;

  wire          win  = !bus_addr[AW-1];
  wire [PB-1:0] psel = bus_addr[AW-2:WSH];
  wire [WSH-1:0] off = bus_addr[WSH-1:0];

  always_comb begin
    for (int i = 0; i < PINS; i++) begin
      en_v[i]    = cfg[i][0];
      dir_v[i]   = cfg[i][1];
      ien_v[i]   = cfg[i][6];
      armed_v[i] = cfg[i][0] && (cfg[i][3:2] != 2'd0);
      clr[i]     = bus_wr && win && (psel == PB'(i)) && (off == O_CLR) && bus_wdata[0];
      case (cfg[i][3:2])
        2'd1:    ev[i] = (filt[i] == cfg[i][4]);
        2'd2:    ev[i] = cfg[i][4] ? (filt[i] & ~filt_d[i]) : (~filt[i] & filt_d[i]);
        2'd3:    ev[i] = filt[i] ^ filt_d[i];
        default: ev[i] = 1'b0;
      endcase
      ev[i] = ev[i] & cfg[i][0];
    end
  end

  always_comb begin
    rd_n = '0;
    if (win) begin
      case (off)
        O_CFG:   rd_n[7:0]     = cfg[psel];
        O_TH:    rd_n[DBW-1:0] = th[psel];
        O_IN:    rd_n[0]       = s2[psel];
        O_FLT:   rd_n[0]       = flt[psel];
        O_OUT:   rd_n[0]       = oval[psel];
        default: rd_n          = '0;
      endcase
    end else if (bus_addr[AW-2:0] == '0) begin
      rd_n[PINS-1:0] = stat;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; filt <= '0; filt_d <= '0; stat <= '0;
      flt <= '0; oval <= '0; bus_rdata <= '0;
      for (int i = 0; i < PINS; i++) begin
        cfg[i] <= '0; th[i] <= '0; cnt[i] <= '0;
      end
    end else begin
      s1        <= pad_in;
      s2        <= s1;
      filt_d    <= filt;
      stat      <= ev | (stat & ~clr);
      bus_rdata <= rd_n;
      for (int i = 0; i < PINS; i++) begin
        if (s2[i] == filt[i]) begin
          cnt[i] <= '0;
        end else if (!cfg[i][5] || (th[i] == '0) ||
                     (({1'b0, cnt[i]} + 1'b1) >= {1'b0, th[i]})) begin
          filt[i] <= s2[i];
          cnt[i]  <= '0;
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
        if (bus_wr && win && (psel == PB'(i))) begin
          case (off)
            O_CFG:   cfg[i]  <= bus_wdata[7:0];
            O_TH:    th[i]   <= bus_wdata[DBW-1:0];
            O_FLT:   flt[i]  <= bus_wdata[0];
            O_OUT:   oval[i] <= bus_wdata[0];
            default: ;
          endcase
        end
      end
    end
  end

  assign pad_out = oval;
  assign pad_oe  = en_v & dir_v & ~flt;
  assign irq     = |(stat & en_v & ien_v);
endmodule

// File: rtl/gpio_event_port_chk.sv
module gpio_event_port_chk #(
  parameter int PINS = 8,
  parameter int DW   = 32,
  parameter int AW   = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [PINS-1:0] pad_oe,
  input logic            irq,
  input logic [PINS-1:0] stat,
  input logic [PINS-1:0] en_v,
  input logic [PINS-1:0] dir_v,
  input logic [PINS-1:0] ien_v,
  input logic [PINS-1:0] armed_v
);
  logic [PINS-1:0] clr_w;
  always_comb
    for (int i = 0; i < PINS; i++)
      clr_w[i] = bus_wr && !bus_addr[AW-1] && (bus_addr[AW-2:5] == (AW-6)'(i)) &&
                 (bus_addr[4:0] == 5'h14) && bus_wdata[0];

  a_r3_oe_needs_output: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~(en_v & dir_v)) == '0);

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1] && (bus_addr[AW-2:0] != '0)) |=> (bus_rdata == '0));

  a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(en_v & ien_v));

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[g] && !clr_w[g]) |=> stat[g]);
    a_r5_armed_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat[g]) |-> $past(armed_v[g]));
  end
endmodule

bind gpio_event_port gpio_event_port_chk #(.PINS(PINS), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe), .irq(irq),
  .stat(stat), .en_v(en_v), .dir_v(dir_v), .ien_v(ien_v), .armed_v(armed_v)
);

// File: tb/test_gpio_event_port.sv
`timescale 1ns/1ps
module test_gpio_event_port;
  logic        clk = 0, rst_n = 0, bus_wr = 0, irq;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, d;
  logic [7:0]  pad = '0, pad_out, pad_oe;
  int checks = 0, errors = 0;
  logic [7:0]  sh_cfg [8];
  logic [15:0] sh_th [8];
  logic [7:0]  sh_flt, sh_out;

  always #10 clk = ~clk;

  gpio_event_port i_gpio_event_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  function automatic int A(int p, int o); return p * 32 + o; endfunction

  function automatic logic [7:0] exp_oe();
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = sh_cfg[i][0] & sh_cfg[i][1] & ~sh_flt[i];
    return r;
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] v);
    @(negedge clk); bus_addr = a[8:0]; bus_wdata = v; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk); bus_addr = a[8:0]; bus_wr = 0;
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic idle(int n); repeat (n) @(negedge clk); endtask
  task automatic setpad(int p, bit v); @(negedge clk); pad[p] = v; endtask
  task automatic stat_is(string r, int p, bit e);
    rd(256, d); chk(r, d[p], e);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; pad = '0; idle(3); rst_n = 1;
    for (int i = 0; i < 8; i++) begin sh_cfg[i] = '0; sh_th[i] = '0; end
    sh_flt = '0; sh_out = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    // R1 reset state
    rd(A(3, 0), d); chk("R1 cfg", d, 0);
    rd(A(5, 4), d); chk("R1 threshold", d, 0);
    rd(256, d);     chk("R1 status", d, 0);
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 irq", irq, 0);
    // R4 synchronised input
    @(negedge clk); pad = 8'hA5; idle(3);
    rd(A(0, 8), d); chk("R4 input pin0", d, 1);
    rd(A(1, 8), d); chk("R4 input pin1", d, 0);
    rd(A(7, 8), d); chk("R4 input pin7", d, 1);
    @(negedge clk); pad = '0; idle(6);
    // R2 / R3 registers and pad drive
    wr(A(3, 0), 32'h83); rd(A(3, 0), d); chk("R2 cfg readback", d, 32'h83);
    wr(A(3, 4), 32'hFFFF1234); rd(A(3, 4), d); chk("R2 threshold readback", d, 32'h1234);
    wr(A(3, 16), 1); rd(A(3, 16), d); chk("R2 out readback", d, 1);
    chk("R3 pad_out", pad_out[3], 1);
    chk("R3 pad_oe driven", pad_oe[3], 1);
    wr(A(3, 12), 1); chk("R3 float releases", pad_oe[3], 0);
    wr(A(5, 0), 32'h02); chk("R3 disabled output", pad_oe[5], 0);
    // R5 single rising edge, mode 2 polarity 1
    wr(A(2, 0), 32'h59);
    setpad(2, 1); idle(6); stat_is("R5 rising event", 2, 1); chk("R10 irq on", irq, 1);
    wr(A(2, 20), 1); stat_is("R6 cleared", 2, 0); chk("R10 irq off", irq, 0);
    setpad(2, 0); idle(6); stat_is("R5 falling ignored in rising mode", 2, 0);
    // falling mode
    wr(A(2, 0), 32'h49);
    setpad(2, 1); idle(6); stat_is("R5 rising ignored in falling mode", 2, 0);
    setpad(2, 0); idle(6); stat_is("R5 falling event", 2, 1);
    wr(A(2, 20), 0); stat_is("R6 clear with bit0=0 keeps", 2, 1);
    wr(A(2, 20), 1);
    // double edge
    wr(A(2, 0), 32'h4D);
    setpad(2, 1); idle(6); stat_is("R5 double rise", 2, 1); wr(A(2, 20), 1);
    setpad(2, 0); idle(6); stat_is("R5 double fall", 2, 1); wr(A(2, 20), 1);
    // no trigger, and disabled pin
    wr(A(2, 0), 32'h41);
    setpad(2, 1); idle(6); setpad(2, 0); idle(6); stat_is("R5 mode 0 silent", 2, 0);
    wr(A(2, 0), 32'h4C);
    setpad(2, 1); idle(6); setpad(2, 0); idle(6); stat_is("R5 disabled silent", 2, 0);
    // R7 level high
    wr(A(4, 0), 32'h55);
    setpad(4, 1); idle(6); stat_is("R7 level set", 4, 1);
    wr(A(4, 20), 1); stat_is("R7 level reasserts after clear", 4, 1);
    setpad(4, 0); idle(6); stat_is("R6 sticky after level gone", 4, 1);
    wr(A(4, 20), 1); stat_is("R7 clear after level gone", 4, 0);
    wr(A(4, 0), 32'h45); idle(2); stat_is("R7 level low active", 4, 1);
    wr(A(4, 0), 0); wr(A(4, 20), 1); stat_is("R7 cleared when disabled", 4, 0);
    // R8 debounce, double edge, threshold 5
    wr(A(6, 4), 5); wr(A(6, 0), 32'h6D);
    @(negedge clk); pad[6] = 1; idle(3); pad[6] = 0; idle(12);
    stat_is("R8 short pulse filtered", 6, 0);
    @(negedge clk); pad[6] = 1; idle(9); pad[6] = 0; idle(14);
    stat_is("R8 long pulse accepted", 6, 1);
    wr(A(6, 20), 1); wr(A(6, 4), 0);
    @(negedge clk); pad[6] = 1; idle(1); pad[6] = 0; idle(8);
    stat_is("R8 threshold 0 passes 1-cycle pulse", 6, 1);
    wr(A(6, 20), 1);
    // R10 interrupt enable gating and timestamp bit
    wr(A(7, 0), 32'h8D); rd(A(7, 0), d); chk("R10 timestamp readback", d, 32'h8D);
    setpad(7, 1); idle(6); stat_is("R10 status without ien", 7, 1);
    chk("R10 irq masked", irq, 0);
    wr(A(7, 0), 32'hCD); chk("R10 irq unmasked", irq, 1);
    wr(A(7, 20), 1); chk("R10 irq after clear", irq, 0);
    setpad(7, 0); idle(6); wr(A(7, 20), 1);
    // R9 zero reads
    rd(9'h104, d); chk("R9 status word 1", d, 0);
    rd(9'h11C, d); chk("R9 status word 7", d, 0);
    rd(9'h180, d); chk("R9 unmapped page", d, 0);
    rd(A(2, 20), d); chk("R9 clear reads zero", d, 0);
    rd(A(2, 24), d); chk("R9 unused offset", d, 0);
    wr(A(2, 0), 32'h59); setpad(2, 1); idle(6);
    rd(9'h100, d); chk("R9 status word 0", d, 32'h4);
    // random register traffic, R2 and R3
    do_reset();
    for (int k = 0; k < 60; k++) begin
      int p, f;
      logic [31:0] v;
      p = $urandom_range(7); f = $urandom_range(3); v = $urandom;
      case (f)
        0: begin wr(A(p, 0), v);  sh_cfg[p] = v[7:0];  rd(A(p, 0), d);  chk("R2 rand cfg", d, {24'h0, sh_cfg[p]}); end
        1: begin wr(A(p, 4), v);  sh_th[p] = v[15:0];  rd(A(p, 4), d);  chk("R2 rand threshold", d, {16'h0, sh_th[p]}); end
        2: begin wr(A(p, 12), v); sh_flt[p] = v[0];    rd(A(p, 12), d); chk("R2 rand float", d, {31'h0, sh_flt[p]}); end
        default: begin wr(A(p, 16), v); sh_out[p] = v[0]; rd(A(p, 16), d); chk("R2 rand out", d, {31'h0, sh_out[p]}); end
      endcase
      chk("R3 rand pad_oe", pad_oe, exp_oe());
      chk("R3 rand pad_out", pad_out, sh_out);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule